// File: doc/BRIEF.md
# Outstanding Line Request Tracker

This block sits between a processor's memory port and its cache controller. It keeps a record of every cache-line request that has been issued and is waiting for completion. Reads and writes go into two separate tables, and each table is looked up by line address. A new request is admitted only when both of these hold: the tracker has spare capacity, and no request that touches the same line is still pending in either table. Every request gets an answer in the same cycle: accepted, refused because of a line conflict, or refused because the tracker is full.

Completion ports for the read side and the write side remove entries and report how many cycles each request was outstanding. Four saturating counters record refused conflicts, split by which request class collided with which. A periodic watchdog raises a sticky deadlock flag when an entry has been waiting too long. A sticky protocol-error flag records any completion that names a line the matching table does not hold.

Top module: `orq_tracker`

## Requirements
- R1: When `req_valid_i` is high and the outstanding count is already at or above `MAX_OUT`, `req_status_o` is 2 (full) and nothing is inserted. The count never goes above `MAX_OUT`.
- R2: A request whose own table has every slot valid is answered 2 (full), even when the count is below `MAX_OUT`.
- R3: Request kinds 0 (load) and 1 (instruction fetch) are read-class. Every other kind is write-class: 2 store, 3 rmw read, 4 rmw write, 5 linked load, 6 conditional store, 7 locked rmw read, 8 locked rmw write, 9 flush. A write-class request for a line held in either table is answered 1 (aliased).
- R4: A read-class request for a line held in either table is answered 1 (aliased). A line is never held twice.
- R5: The full answer takes priority over the aliased answer. A refused request leaves the count and the tables unchanged. An accepted request is answered 0 (ready).
- R6: Each aliased refusal increments exactly one of four counters. A write-class request that hits the read table increments store-behind-load. A write-class request that hits only the write table increments store-behind-store. A read-class request that hits the write table increments load-behind-store. Any other read-class refusal increments load-behind-load. A full refusal increments none of them.
- R7: `outstanding_o` equals the number of valid entries in the two tables. It rises by one on each acceptance and falls by one on each retirement. A read retirement and a write retirement may happen in the same cycle.
- R8: A completion that hits an entry raises its `*_lat_valid_o` in that cycle. The matching `*_lat_o` gives the current cycle minus the cycle in which the request was accepted.
- R9: A completion for a line that is absent from the matching table sets `prot_err_o` from the next cycle until reset, and changes no table state.
- R10: The first acceptance while the watchdog is idle starts a check that falls `AGE_LIMIT` cycles later. If any entry's age is at least `AGE_LIMIT` at that check, `deadlock_o` rises on the following cycle and stays high until reset.
- R11: After each check the watchdog starts a new `AGE_LIMIT`-cycle period while any request is outstanding, and goes idle otherwise.
- R12: After reset the count, both flags and all four counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A new request is presented |
| req_kind_i | input | 4 | Request kind code (see R3) |
| req_line_i | input | LINE_W | Line address of the request |
| req_status_o | output | 2 | Same-cycle answer: 0 ready, 1 aliased, 2 full |
| rd_done_i | input | 1 | Read completion strobe |
| rd_done_line_i | input | LINE_W | Line address of the read completion |
| wr_done_i | input | 1 | Write completion strobe |
| wr_done_line_i | input | LINE_W | Line address of the write completion |
| rd_lat_valid_o | output | 1 | Read completion hit an entry |
| rd_lat_o | output | CYC_W | Latency of the retired read |
| wr_lat_valid_o | output | 1 | Write completion hit an entry |
| wr_lat_o | output | CYC_W | Latency of the retired write |
| outstanding_o | output | CNT_W | Number of requests in flight |
| hz_st_ld_o | output | HZ_W | Store-behind-load refusals |
| hz_st_st_o | output | HZ_W | Store-behind-store refusals |
| hz_ld_ld_o | output | HZ_W | Load-behind-load refusals |
| hz_ld_st_o | output | HZ_W | Load-behind-store refusals |
| prot_err_o | output | 1 | Sticky flag for a completion with no entry |
| deadlock_o | output | 1 | Sticky watchdog flag |

## Verification
The assertions take for granted that the request and completion inputs hold steady across each rising edge. They also assume that reset is applied before the first request. Completions that name absent lines are allowed, because the tracker must tolerate them. The bench changes every input on the falling edge of the clock. It sends absent-line completions only in the dedicated protocol-error sequence. Each sequence starts from a fresh reset, so the sticky flags of one sequence never hide the results of the next.

// File: rtl/orq_pkg.sv
package orq_pkg;

  typedef enum logic [1:0] {
    ST_READY   = 2'd0,
    ST_ALIASED = 2'd1,
    ST_FULL    = 2'd2
  } orq_status_e;

  typedef enum logic [3:0] {
    K_LOAD    = 4'd0,
    K_IFETCH  = 4'd1,
    K_STORE   = 4'd2,
    K_RMW_RD  = 4'd3,
    K_RMW_WR  = 4'd4,
    K_LINK_LD = 4'd5,
    K_COND_ST = 4'd6,
    K_LOCK_RD = 4'd7,
    K_LOCK_WR = 4'd8,
    K_FLUSH   = 4'd9
  } orq_kind_e;

  // Index of each hazard counter in the counter bank.
  localparam int HZ_ST_LD = 0;
  localparam int HZ_ST_ST = 1;
  localparam int HZ_LD_LD = 2;
  localparam int HZ_LD_ST = 3;
  localparam int HZ_NUM   = 4;

  function automatic logic kind_is_read(input logic [3:0] kind);
    return (kind == K_LOAD) || (kind == K_IFETCH);
  endfunction

endpackage

// File: rtl/orq_line_table.sv
module orq_line_table #(
  parameter int ENTRIES   = 4,
  parameter int LINE_W    = 16,
  parameter int CYC_W     = 16,
  parameter int AGE_LIMIT = 40,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int OCC_W    = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  now_i,
  input  logic [LINE_W-1:0] probe_line_i,
  output logic              probe_hit_o,
  output logic              full_o,
  output logic [OCC_W-1:0]  occ_o,
  input  logic              ins_en_i,
  input  logic [LINE_W-1:0] ins_line_i,
  input  logic              ret_en_i,
  input  logic [LINE_W-1:0] ret_line_i,
  output logic              ret_hit_o,
  output logic [CYC_W-1:0]  ret_lat_o,
  output logic              stale_o
);

  localparam logic [CYC_W-1:0] LIMIT_C = CYC_W'(AGE_LIMIT);

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ENTRIES-1:0] probe_match, ret_match, old_vec;
  logic [LINE_W-1:0]  line_q  [ENTRIES];
  logic [CYC_W-1:0]   issue_q [ENTRIES];
  logic [CYC_W-1:0]   age     [ENTRIES];
  logic [IDX_W-1:0]   free_idx;
  logic               free_found;

  // Per-entry comparators: fully associative lookup.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign age[g]         = now_i - issue_q[g];
    assign probe_match[g] = vld_q[g] && (line_q[g] == probe_line_i);
    assign ret_match[g]   = vld_q[g] && (line_q[g] == ret_line_i);
    assign old_vec[g]     = vld_q[g] && (age[g] >= LIMIT_C);
  end

  // Lowest free slot.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    occ_o     = '0;
    ret_lat_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      occ_o = occ_o + OCC_W'(vld_q[i]);
      if (ret_match[i]) ret_lat_o = ret_lat_o | age[i];
    end
  end

  assign probe_hit_o = |probe_match;
  assign ret_hit_o   = |ret_match;
  assign full_o      = ~free_found;
  assign stale_o     = |old_vec;

  // Next state of the valid bits.
  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ret_en_i && ret_match[i]) vld_d[i] = 1'b0;
      if (ins_en_i && free_found && (free_idx == IDX_W'(i))) vld_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Payload registers, written only on insertion (clock enable).
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (ins_en_i && free_found && (free_idx == IDX_W'(i))) begin
        line_q[i]  <= ins_line_i;
        issue_q[i] <= now_i;
      end
    end
  end

  AST_UNIQUE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_match)) else $error("line held twice");   // R4
  AST_INS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en_i |-> !full_o) else $error("insert into full table"); // R2

endmodule

// File: rtl/orq_watchdog.sv
module orq_watchdog #(
  parameter int AGE_LIMIT = 40,
  localparam int TMR_W    = $clog2(AGE_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic insert_i,
  input  logic busy_i,
  input  logic stale_i,
  output logic deadlock_o
);

  localparam logic [TMR_W-1:0] RELOAD = TMR_W'(AGE_LIMIT - 1);

  logic             armed_q, armed_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             dl_q, dl_d;
  logic             check;

  assign check = armed_q && (tmr_q == '0);

  always_comb begin
    armed_d = armed_q;
    tmr_d   = tmr_q;
    dl_d    = dl_q;
    if (check) begin
      dl_d = dl_q | stale_i;
      if (busy_i || insert_i) begin
        armed_d = 1'b1;
        tmr_d   = RELOAD;
      end else begin
        armed_d = 1'b0;
      end
    end else if (armed_q) begin
      tmr_d = tmr_q - 1'b1;
    end else if (insert_i) begin
      armed_d = 1'b1;
      tmr_d   = RELOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      tmr_q   <= '0;
      dl_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      tmr_q   <= tmr_d;
      dl_q    <= dl_d;
    end
  end

  assign deadlock_o = dl_q;

  AST_DEADLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dl_q |=> dl_q) else $error("deadlock flag dropped");       // R10
  AST_FLAG_ONLY_AT_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dl_q) |-> $past(check)) else $error("flag outside check"); // R11

endmodule

// File: rtl/orq_sat_ctr.sv
module orq_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && (cnt_q != '1)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/orq_tracker.sv
module orq_tracker
  import orq_pkg::*;
#(
  parameter int LINE_W     = 16,
  parameter int RD_ENTRIES = 4,
  parameter int WR_ENTRIES = 4,
  parameter int MAX_OUT    = 6,
  parameter int AGE_LIMIT  = 40,
  parameter int CYC_W      = 16,
  parameter int HZ_W       = 16,
  localparam int CNT_W     = $clog2(RD_ENTRIES + WR_ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [3:0]        req_kind_i,
  input  logic [LINE_W-1:0] req_line_i,
  output logic [1:0]        req_status_o,
  input  logic              rd_done_i,
  input  logic [LINE_W-1:0] rd_done_line_i,
  input  logic              wr_done_i,
  input  logic [LINE_W-1:0] wr_done_line_i,
  output logic              rd_lat_valid_o,
  output logic [CYC_W-1:0]  rd_lat_o,
  output logic              wr_lat_valid_o,
  output logic [CYC_W-1:0]  wr_lat_o,
  output logic [CNT_W-1:0]  outstanding_o,
  output logic [HZ_W-1:0]   hz_st_ld_o,
  output logic [HZ_W-1:0]   hz_st_st_o,
  output logic [HZ_W-1:0]   hz_ld_ld_o,
  output logic [HZ_W-1:0]   hz_ld_st_o,
  output logic              prot_err_o,
  output logic              deadlock_o
);

  localparam int RD_OCC_W = $clog2(RD_ENTRIES + 1);
  localparam int WR_OCC_W = $clog2(WR_ENTRIES + 1);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_OUT);

  orq_status_e         status;
  logic                is_rd;
  logic                rd_hit, wr_hit, rd_full, wr_full, tbl_full, at_cap;
  logic                accept, aliased;
  logic                rd_ins, wr_ins;
  logic                rd_ret_hit, wr_ret_hit, rd_ret, wr_ret;
  logic                rd_stale, wr_stale;
  logic [RD_OCC_W-1:0] rd_occ;
  logic [WR_OCC_W-1:0] wr_occ;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [CYC_W-1:0]    now_q, now_d;
  logic                perr_q, perr_d;
  logic [HZ_NUM-1:0]   hz_inc;
  logic [HZ_W-1:0]     hz_cnt [HZ_NUM];

  // ---------------- admission decision ----------------
  assign is_rd    = kind_is_read(req_kind_i);
  assign at_cap   = (cnt_q >= MAX_C);
  assign tbl_full = is_rd ? rd_full : wr_full;

  always_comb begin
    status = ST_READY;
    if (req_valid_i) begin
      if (at_cap || tbl_full)    status = ST_FULL;
      else if (rd_hit || wr_hit) status = ST_ALIASED;
    end
  end

  assign req_status_o = status;
  assign accept  = req_valid_i && (status == ST_READY);
  assign aliased = req_valid_i && (status == ST_ALIASED);
  assign rd_ins  = accept && is_rd;
  assign wr_ins  = accept && !is_rd;

  // Hazard classification: a write-class request checks the read table first.
  always_comb begin
    hz_inc = '0;
    if (aliased) begin
      if (!is_rd) begin
        if (rd_hit) hz_inc[HZ_ST_LD] = 1'b1;
        else        hz_inc[HZ_ST_ST] = 1'b1;
      end else begin
        if (wr_hit) hz_inc[HZ_LD_ST] = 1'b1;
        else        hz_inc[HZ_LD_LD] = 1'b1;
      end
    end
  end

  // ---------------- tables ----------------
  orq_line_table #(
    .ENTRIES(RD_ENTRIES), .LINE_W(LINE_W), .CYC_W(CYC_W), .AGE_LIMIT(AGE_LIMIT)
  ) rd_tbl_i (
    .clk(clk), .rst_n(rst_n), .now_i(now_q),
    .probe_line_i(req_line_i), .probe_hit_o(rd_hit), .full_o(rd_full), .occ_o(rd_occ),
    .ins_en_i(rd_ins), .ins_line_i(req_line_i),
    .ret_en_i(rd_done_i), .ret_line_i(rd_done_line_i),
    .ret_hit_o(rd_ret_hit), .ret_lat_o(rd_lat_o), .stale_o(rd_stale)
  );

  orq_line_table #(
    .ENTRIES(WR_ENTRIES), .LINE_W(LINE_W), .CYC_W(CYC_W), .AGE_LIMIT(AGE_LIMIT)
  ) wr_tbl_i (
    .clk(clk), .rst_n(rst_n), .now_i(now_q),
    .probe_line_i(req_line_i), .probe_hit_o(wr_hit), .full_o(wr_full), .occ_o(wr_occ),
    .ins_en_i(wr_ins), .ins_line_i(req_line_i),
    .ret_en_i(wr_done_i), .ret_line_i(wr_done_line_i),
    .ret_hit_o(wr_ret_hit), .ret_lat_o(wr_lat_o), .stale_o(wr_stale)
  );

  assign rd_ret         = rd_done_i && rd_ret_hit;
  assign wr_ret         = wr_done_i && wr_ret_hit;
  assign rd_lat_valid_o = rd_ret;
  assign wr_lat_valid_o = wr_ret;

  // ---------------- count, time base, error flag ----------------
  always_comb begin
    cnt_d  = cnt_q + CNT_W'(accept) - CNT_W'(rd_ret) - CNT_W'(wr_ret);
    now_d  = now_q + 1'b1;
    perr_d = perr_q | (rd_done_i && !rd_ret_hit) | (wr_done_i && !wr_ret_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      now_q  <= '0;
      perr_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      now_q  <= now_d;
      perr_q <= perr_d;
    end
  end

  assign outstanding_o = cnt_q;
  assign prot_err_o    = perr_q;

  // ---------------- watchdog and counters ----------------
  orq_watchdog #(.AGE_LIMIT(AGE_LIMIT)) wdog_i (
    .clk(clk), .rst_n(rst_n), .insert_i(accept), .busy_i(cnt_q != '0),
    .stale_i(rd_stale | wr_stale), .deadlock_o(deadlock_o)
  );

  for (genvar h = 0; h < HZ_NUM; h++) begin : g_hz
    orq_sat_ctr #(.W(HZ_W)) ctr_i (
      .clk(clk), .rst_n(rst_n), .inc_i(hz_inc[h]), .cnt_o(hz_cnt[h])
    );
  end

  assign hz_st_ld_o = hz_cnt[HZ_ST_LD];
  assign hz_st_st_o = hz_cnt[HZ_ST_ST];
  assign hz_ld_ld_o = hz_cnt[HZ_LD_LD];
  assign hz_ld_st_o = hz_cnt[HZ_LD_ST];

  // ---------------- assertions ----------------
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_C) else $error("count above limit");                          // R1
  AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == (CNT_W'(rd_occ) + CNT_W'(wr_occ))) else $error("count mismatch"); // R7
  AST_REFUSE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (status != ST_READY)) |=> (cnt_q <= $past(cnt_q)))
    else $error("refused request grew count");                                 // R5
  AST_NO_DUAL_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hit && wr_hit)) else $error("line in both tables");                   // R3
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q |=> perr_q) else $error("protocol error dropped");                  // R9
  AST_HZ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hz_inc)) else $error("two hazard counters bumped");               // R6

endmodule

// File: tb/orq_tracker_tb.sv
`timescale 1ns/1ps
module orq_tracker_tb_top;

  localparam int LINE_W = 16;
  localparam int CYC_W  = 16;
  localparam int HZ_W   = 16;
  localparam int LIMIT  = 40;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [3:0]        req_kind;
  logic [LINE_W-1:0] req_line;
  logic [1:0]        req_status;
  logic              rd_done, wr_done;
  logic [LINE_W-1:0] rd_done_line, wr_done_line;
  logic              rd_lat_valid, wr_lat_valid;
  logic [CYC_W-1:0]  rd_lat, wr_lat;
  logic [3:0]        outstanding;
  logic [HZ_W-1:0]   hz_st_ld, hz_st_st, hz_ld_ld, hz_ld_st;
  logic              prot_err, deadlock;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;  // 50 MHz

  orq_tracker dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_line_i(req_line),
    .req_status_o(req_status),
    .rd_done_i(rd_done), .rd_done_line_i(rd_done_line),
    .wr_done_i(wr_done), .wr_done_line_i(wr_done_line),
    .rd_lat_valid_o(rd_lat_valid), .rd_lat_o(rd_lat),
    .wr_lat_valid_o(wr_lat_valid), .wr_lat_o(wr_lat),
    .outstanding_o(outstanding),
    .hz_st_ld_o(hz_st_ld), .hz_st_st_o(hz_st_st),
    .hz_ld_ld_o(hz_ld_ld), .hz_ld_st_o(hz_ld_st),
    .prot_err_o(prot_err), .deadlock_o(deadlock)
  );

  // Status codes and kinds used by the bench (see R3, R5).
  localparam logic [1:0] RDY = 2'd0, ALI = 2'd1, FUL = 2'd2;
  localparam logic [1:0] OP_REQ = 2'd0, OP_RDONE = 2'd1, OP_WDONE = 2'd2;

  // {op, kind, line, expected status, expected count afterwards}
  localparam int NVEC = 16;
  localparam logic [27:0] VEC [NVEC] = '{
    {OP_REQ,   4'd0, 16'h0010, RDY, 4'd1},  // R4 load accepted
    {OP_REQ,   4'd1, 16'h0010, ALI, 4'd1},  // R4 fetch behind load
    {OP_REQ,   4'd2, 16'h0010, ALI, 4'd1},  // R3 store behind load
    {OP_REQ,   4'd2, 16'h0020, RDY, 4'd2},  // R3 store accepted
    {OP_REQ,   4'd0, 16'h0020, ALI, 4'd2},  // R4 load behind store
    {OP_REQ,   4'd6, 16'h0020, ALI, 4'd2},  // R3 cond store behind store
    {OP_REQ,   4'd9, 16'h0030, RDY, 4'd3},  // R3 flush
    {OP_REQ,   4'd1, 16'h0040, RDY, 4'd4},  // R4 fetch
    {OP_RDONE, 4'd0, 16'h0010, RDY, 4'd3},  // R7 retire read
    {OP_REQ,   4'd2, 16'h0010, RDY, 4'd4},  // R3 line free again
    {OP_WDONE, 4'd0, 16'h0020, RDY, 4'd3},  // R7 retire write
    {OP_REQ,   4'd5, 16'h0020, RDY, 4'd4},  // R3 linked load is write-class
    {OP_REQ,   4'd0, 16'h0050, RDY, 4'd5},
    {OP_REQ,   4'd8, 16'h0060, RDY, 4'd6},
    {OP_REQ,   4'd0, 16'h0070, FUL, 4'd6},  // R1 at capacity
    {OP_REQ,   4'd0, 16'h0010, FUL, 4'd6}   // R5 full beats aliased
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_line = '0;
    rd_done = 1'b0; wr_done = 1'b0; rd_done_line = '0; wr_done_line = '0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic do_req(input logic [3:0] k, input logic [15:0] ln,
                        input logic [1:0] exp, input string tag);
    req_valid = 1'b1; req_kind = k; req_line = ln;
    #1 check(32'(req_status), 32'(exp), tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // exp_lat of 16'hFFFF means "hit expected, latency not checked".
  task automatic do_ret(input logic rv, input logic [15:0] rl, input logic rhit, input logic [15:0] rlat,
                        input logic wv, input logic [15:0] wl, input logic whit, input logic [15:0] wlat,
                        input string tag);
    rd_done = rv; rd_done_line = rl; wr_done = wv; wr_done_line = wl;
    #1;
    if (rv) begin
      check(32'(rd_lat_valid), 32'(rhit), {tag, " rd hit"});
      if (rhit && rlat != 16'hFFFF) check(32'(rd_lat), 32'(rlat), {tag, " rd latency"});
    end
    if (wv) begin
      check(32'(wr_lat_valid), 32'(whit), {tag, " wr hit"});
      if (whit && wlat != 16'hFFFF) check(32'(wr_lat), 32'(wlat), {tag, " wr latency"});
    end
    @(negedge clk);
    rd_done = 1'b0; wr_done = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R12 reset state
    check(32'(outstanding), 0, "R12 count");
    check(32'(prot_err), 0, "R12 prot_err");
    check(32'(deadlock), 0, "R12 deadlock");
    check(32'(hz_st_ld) + 32'(hz_st_st) + 32'(hz_ld_ld) + 32'(hz_ld_st), 0, "R12 counters");

    // Vector table: admission, aliasing, retirement, capacity
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0]  op;
      logic [3:0]  kd;
      logic [15:0] ln;
      logic [1:0]  es;
      logic [3:0]  ec;
      {op, kd, ln, es, ec} = VEC[v];
      if (op == OP_REQ)
        do_req(kd, ln, es, $sformatf("R3/R4/R5 vec%0d status", v));
      else if (op == OP_RDONE)
        do_ret(1'b1, ln, 1'b1, 16'hFFFF, 1'b0, '0, 1'b0, 16'h0, $sformatf("R7 vec%0d", v));
      else
        do_ret(1'b0, '0, 1'b0, 16'h0, 1'b1, ln, 1'b1, 16'hFFFF, $sformatf("R7 vec%0d", v));
      check(32'(outstanding), 32'(ec), $sformatf("R7 vec%0d count", v));
    end
    check(32'(hz_st_ld), 1, "R6 store-behind-load");
    check(32'(hz_st_st), 1, "R6 store-behind-store");
    check(32'(hz_ld_ld), 1, "R6 load-behind-load");
    check(32'(hz_ld_st), 1, "R6 load-behind-store (full refusal not counted)");

    // R7 read and write retire in the same cycle
    do_ret(1'b1, 16'h0040, 1'b1, 16'hFFFF, 1'b1, 16'h0030, 1'b1, 16'hFFFF, "R7 dual");
    check(32'(outstanding), 4, "R7 dual retire count");

    // R2 read table full while below capacity
    do_reset();
    for (int i = 1; i <= 4; i++) do_req(4'd0, 16'(i), RDY, "R2 fill");
    do_req(4'd1, 16'h0005, FUL, "R2 read table full");
    do_req(4'd2, 16'h0005, RDY, "R2 write side still open");
    check(32'(outstanding), 5, "R2 count");

    // R8 latency
    do_reset();
    do_req(4'd7, 16'h0055, RDY, "R8 insert");
    idle(4);
    do_ret(1'b0, '0, 1'b0, 16'h0, 1'b1, 16'h0055, 1'b1, 16'd5, "R8");
    check(32'(outstanding), 0, "R8 count");

    // R9 completion for an absent line
    do_reset();
    do_ret(1'b0, '0, 1'b0, 16'h0, 1'b1, 16'h0077, 1'b0, 16'h0, "R9 absent");
    check(32'(prot_err), 1, "R9 flag set");
    do_req(4'd0, 16'h0088, RDY, "R9 insert read");
    do_ret(1'b0, '0, 1'b0, 16'h0, 1'b1, 16'h0088, 1'b0, 16'h0, "R9 wrong table");
    check(32'(outstanding), 1, "R9 entry kept");
    idle(3);
    check(32'(prot_err), 1, "R9 sticky");
    do_ret(1'b1, 16'h0088, 1'b1, 16'hFFFF, 1'b0, '0, 1'b0, 16'h0, "R9 right table");

    // R10 single check after AGE_LIMIT cycles
    do_reset();
    do_req(4'd0, 16'h0100, RDY, "R10 insert");
    idle(LIMIT - 1);
    check(32'(deadlock), 0, "R10 before check");
    idle(1);
    check(32'(deadlock), 1, "R10 flagged");
    idle(5);
    check(32'(deadlock), 1, "R10 sticky");

    // R11 periodic re-arm
    do_reset();
    do_req(4'd0, 16'h0200, RDY, "R11 insert A");
    idle(9);
    do_ret(1'b1, 16'h0200, 1'b1, 16'd10, 1'b0, '0, 1'b0, 16'h0, "R11 retire A");
    idle(9);
    do_req(4'd2, 16'h0300, RDY, "R11 insert B");
    idle(59);
    check(32'(deadlock), 0, "R11 first check saw young entry");
    idle(1);
    check(32'(deadlock), 1, "R11 second check flags");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule